// File: doc/BRIEF.md
# Two-Level Page Walker with Translation Buffer

This block turns 32-bit linear addresses into physical addresses for a simple processor model. Pages are 4 KiB, and the page tables live in memory as two levels: a directory and one table per directory entry. A request carries a linear address and a write flag. The block first searches a small fully associative translation buffer. On a miss it reads the directory entry and then the table entry through a single memory port. It writes the table entry back when its status bits have to change, and then answers with either a physical address or a page fault.

The directory-base register is written directly. Every write to it empties the translation buffer, even when the value written is the value already held. Nothing else empties the buffer. A translation that is still cached therefore keeps being used after its entry in memory has been cleared, until the base register is written again. The linear address of the most recent fault is held in a fault-address register.

Top module: `pgwalk_xlate`

## Requirements
- R1: A walk reads the directory entry at `{dir_base[31:12], LA[31:22], 2'b00}`. It then reads the table entry at `{PDE[31:12], LA[21:12], 2'b00}`. The response carries `{PTE[31:12], LA[11:0]}` as the physical address.
- R2: If bit 0 (present) of the directory entry is clear, the response reports a fault after that one memory read, and the table entry is not read.
- R3: If bit 0 of the table entry is clear, the response reports a fault with a physical address of zero. Nothing is cached, so the next access to the same page walks again.
- R4: On every fault, `fault_addr` captures the full faulting linear address. Responses without a fault leave it unchanged.
- R5: An access that hits the translation buffer makes no memory access. It returns the cached frame even after the table entry in memory has been cleared.
- R6: Writing `dir_base` empties every buffer entry, even when the value written is unchanged. `dir_base` shows the written value on the next cycle.
- R7: A walk sets the accessed bit (bit 5) of the table entry by writing the entry back. A read walk whose entry already has bit 5 set makes no memory write.
- R8: A write access that walks writes the table entry back with the dirty bit (bit 6) set, along with bit 5.
- R9: A write that hits a buffer entry cached with its dirty flag clear performs a full walk and write-back before it responds. A later write to that page then hits with no memory access.
- R10: The buffer holds 8 entries. Emptying it resets the replacement pointer to slot 0, and fills then use the slots in turn. The ninth distinct page therefore evicts the first one filled, and the other pages stay cached.
- R11: `req_ready` is high only while the block is idle. A response holds `rsp_valid`, `rsp_fault` and `rsp_pa` steady until `rsp_ready` is seen. A memory request holds its address and direction until `mem_ack`.
- R12: Two linear pages whose table entries name the same frame translate to the same physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_la | input | 32 | Linear address to translate |
| req_wr | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 1 | Page fault (translation exception 14) |
| rsp_pa | output | 32 | Physical address, zero on a fault |
| base_wr | input | 1 | Write strobe for the directory-base register |
| base_din | input | 32 | Value for the directory-base register |
| dir_base | output | 32 | Current directory-base register |
| fault_addr | output | 32 | Linear address of the last fault |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |

## Verification
The assertions check the following on every cycle:
- the handshake rules;
- that a fault response carries a zero address;
- that the fault register matches the address of the accepted request;
- that a successful response keeps the page offset;
- that every table write-back has present and accessed set, and has dirty set for a write access.

Only the bench scenarios can show what depends on history held in the buffer:
- that a hit makes no memory access and survives a cleared entry in memory;
- that a write to the base register with an unchanged value still forces a new walk;
- that a clean write hit is upgraded;
- the round-robin eviction order;
- aliasing between two pages.

// File: rtl/pw_pkg.sv
package pw_pkg;
   localparam int PW_PRESENT_BIT  = 0;
   localparam int PW_ACCESSED_BIT = 5;
   localparam int PW_DIRTY_BIT    = 6;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_DIR_RD,
      ST_TBL_RD,
      ST_TBL_WR,
      ST_FILL,
      ST_RESP
   } pw_state_e;
endpackage

// File: rtl/pw_rr_ptr.sv
module pw_rr_ptr #(
   parameter int DEPTH = 8,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          advance,
   output logic [PW-1:0] ptr
);
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      always_ff @(posedge clk) begin
         if (!rst_n || clear) ptr <= '0;
         else if (advance)    ptr <= ptr + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n || clear) ptr <= '0;
         else if (advance)    ptr <= (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
      end
   end
endmodule

// File: rtl/pw_tlb.sv
module pw_tlb #(
   parameter int DEPTH = 8,
   parameter int VPN_W = 20,
   parameter int PFN_W = 20,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] look_vpn,
   output logic             hit,
   output logic [PFN_W-1:0] hit_pfn,
   output logic             hit_dirty,
   input  logic             fill_en,
   input  logic             fill_at_hit,
   input  logic [PFN_W-1:0] fill_pfn,
   input  logic             fill_dirty
);
   logic [DEPTH-1:0] vld_q, dirty_q, match;
   logic [VPN_W-1:0] vpn_q [DEPTH];
   logic [PFN_W-1:0] pfn_q [DEPTH];
   logic [IW-1:0]    hit_idx, rr_idx, wr_idx;
   logic             do_fill;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (vpn_q[g] == look_vpn);
   end

   always_comb begin
      hit_idx = '0;
      for (int i = 0; i < DEPTH; i++)
         if (match[i]) hit_idx = hit_idx | IW'(i);
   end

   assign hit       = |match;
   assign hit_pfn   = pfn_q[hit_idx];
   assign hit_dirty = dirty_q[hit_idx];
   assign do_fill   = fill_en && !flush;
   assign wr_idx    = fill_at_hit ? hit_idx : rr_idx;

   pw_rr_ptr #(.DEPTH(DEPTH)) rr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (flush),
      .advance (do_fill && !fill_at_hit),
      .ptr     (rr_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q   <= '0;
         dirty_q <= '0;
      end else if (flush) begin
         vld_q   <= '0;
      end else if (do_fill) begin
         vld_q[wr_idx]   <= 1'b1;
         dirty_q[wr_idx] <= fill_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (do_fill) begin
         vpn_q[wr_idx] <= look_vpn;
         pfn_q[wr_idx] <= fill_pfn;
      end
   end
endmodule

// File: rtl/pgwalk_xlate.sv
module pgwalk_xlate
   import pw_pkg::*;
#(
   parameter int PAGE_BITS = 12,
   parameter int IDX_BITS  = 10,
   parameter int TLB_DEPTH = 8,
   localparam int VPN_W = 2 * IDX_BITS,
   localparam int LA_W  = VPN_W + PAGE_BITS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [LA_W-1:0] req_la,
   input  logic            req_wr,
   output logic            rsp_valid,
   input  logic            rsp_ready,
   output logic            rsp_fault,
   output logic [LA_W-1:0] rsp_pa,
   input  logic            base_wr,
   input  logic [LA_W-1:0] base_din,
   output logic [LA_W-1:0] dir_base,
   output logic [LA_W-1:0] fault_addr,
   output logic            mem_req,
   output logic            mem_we,
   output logic [LA_W-1:0] mem_addr,
   output logic [LA_W-1:0] mem_wdata,
   input  logic [LA_W-1:0] mem_rdata,
   input  logic            mem_ack
);
   if (TLB_DEPTH < 2) begin : g_bad_depth
      $error("TLB_DEPTH must be at least 2");
   end
   if (PAGE_BITS <= PW_DIRTY_BIT) begin : g_bad_page
      $error("PAGE_BITS must leave room for the status bits");
   end
   if (IDX_BITS + 2 > PAGE_BITS) begin : g_bad_idx
      $error("a table of IDX_BITS entries must fit in one page");
   end

   localparam int FRM_W = LA_W - PAGE_BITS;

   pw_state_e        st;
   logic [LA_W-1:0]  la_q, pte_q, new_pte, dir_addr, tbl_addr;
   logic [FRM_W-1:0] pde_frm_q, tlb_pfn;
   logic             wr_q, tlb_hit, tlb_dirty, rsp_fault_q;
   logic [LA_W-1:0]  rsp_pa_q, base_q, fault_q;

   assign dir_addr = {base_q[LA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}}
                   | (LA_W'(la_q[LA_W-1 -: IDX_BITS]) << 2);
   assign tbl_addr = {pde_frm_q, {PAGE_BITS{1'b0}}}
                   | (LA_W'(la_q[PAGE_BITS +: IDX_BITS]) << 2);
   assign new_pte  = mem_rdata | (LA_W'(1) << PW_ACCESSED_BIT)
                   | (wr_q ? (LA_W'(1) << PW_DIRTY_BIT) : '0);

   pw_tlb #(.DEPTH(TLB_DEPTH), .VPN_W(VPN_W), .PFN_W(FRM_W)) tlb_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (base_wr),
      .look_vpn    (la_q[LA_W-1:PAGE_BITS]),
      .hit         (tlb_hit),
      .hit_pfn     (tlb_pfn),
      .hit_dirty   (tlb_dirty),
      .fill_en     (st == ST_FILL),
      .fill_at_hit (tlb_hit),
      .fill_pfn    (pte_q[LA_W-1:PAGE_BITS]),
      .fill_dirty  (pte_q[PW_DIRTY_BIT])
   );

   always_ff @(posedge clk) begin
      if (!rst_n) base_q <= '0;
      else if (base_wr) base_q <= base_din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         la_q        <= '0;
         wr_q        <= 1'b0;
         pde_frm_q   <= '0;
         pte_q       <= '0;
         rsp_pa_q    <= '0;
         rsp_fault_q <= 1'b0;
         fault_q     <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (req_valid) begin
               la_q <= req_la;
               wr_q <= req_wr;
               st   <= ST_LOOKUP;
            end
            ST_LOOKUP: if (tlb_hit && (!wr_q || tlb_dirty)) begin
               rsp_pa_q    <= {tlb_pfn, la_q[PAGE_BITS-1:0]};
               rsp_fault_q <= 1'b0;
               st          <= ST_RESP;
            end else begin
               st <= ST_DIR_RD;
            end
            ST_DIR_RD: if (mem_ack) begin
               if (!mem_rdata[PW_PRESENT_BIT]) begin
                  rsp_pa_q    <= '0;
                  rsp_fault_q <= 1'b1;
                  fault_q     <= la_q;
                  st          <= ST_RESP;
               end else begin
                  pde_frm_q <= mem_rdata[LA_W-1:PAGE_BITS];
                  st        <= ST_TBL_RD;
               end
            end
            ST_TBL_RD: if (mem_ack) begin
               if (!mem_rdata[PW_PRESENT_BIT]) begin
                  rsp_pa_q    <= '0;
                  rsp_fault_q <= 1'b1;
                  fault_q     <= la_q;
                  st          <= ST_RESP;
               end else begin
                  pte_q <= new_pte;
                  st    <= (new_pte != mem_rdata) ? ST_TBL_WR : ST_FILL;
               end
            end
            ST_TBL_WR: if (mem_ack) st <= ST_FILL;
            ST_FILL: begin
               rsp_pa_q    <= {pte_q[LA_W-1:PAGE_BITS], la_q[PAGE_BITS-1:0]};
               rsp_fault_q <= 1'b0;
               st          <= ST_RESP;
            end
            ST_RESP: if (rsp_ready) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (st == ST_IDLE);
   assign rsp_valid  = (st == ST_RESP);
   assign rsp_fault  = rsp_fault_q;
   assign rsp_pa     = rsp_pa_q;
   assign dir_base   = base_q;
   assign fault_addr = fault_q;
   assign mem_req    = (st == ST_DIR_RD) || (st == ST_TBL_RD) || (st == ST_TBL_WR);
   assign mem_we     = (st == ST_TBL_WR);
   assign mem_addr   = (st == ST_DIR_RD) ? dir_addr : tbl_addr;
   assign mem_wdata  = pte_q;
endmodule

// File: rtl/pgwalk_xlate_chk.sv
module pgwalk_xlate_chk #(
   parameter int LA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [LA_W-1:0] req_la,
   input logic            req_wr,
   input logic            rsp_valid,
   input logic            rsp_ready,
   input logic            rsp_fault,
   input logic [LA_W-1:0] rsp_pa,
   input logic            base_wr,
   input logic [LA_W-1:0] base_din,
   input logic [LA_W-1:0] dir_base,
   input logic [LA_W-1:0] fault_addr,
   input logic            mem_req,
   input logic            mem_we,
   input logic [LA_W-1:0] mem_addr,
   input logic [LA_W-1:0] mem_wdata,
   input logic            mem_ack
);
   logic [LA_W-1:0] acc_la;
   logic            acc_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_la <= '0;
         acc_wr <= 1'b0;
      end else if (req_valid && req_ready) begin
         acc_la <= req_la;
         acc_wr <= req_wr;
      end
   end

   AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid || mem_req) |-> !req_ready);                               // R11
   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault))); // R11
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11
   AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_pa == '0));                         // R3
   AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (fault_addr == acc_la));                 // R4
   AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |-> (rsp_pa[11:0] == acc_la[11:0]));        // R1
   AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_wdata[5] && mem_wdata[0]));              // R7
   AST_WB_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && acc_wr) |-> mem_wdata[6]);                      // R8
   AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      base_wr |=> (dir_base == $past(base_din)));                          // R6
endmodule

bind pgwalk_xlate pgwalk_xlate_chk #(.LA_W(LA_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_la     (req_la),
   .req_wr     (req_wr),
   .rsp_valid  (rsp_valid),
   .rsp_ready  (rsp_ready),
   .rsp_fault  (rsp_fault),
   .rsp_pa     (rsp_pa),
   .base_wr    (base_wr),
   .base_din   (base_din),
   .dir_base   (dir_base),
   .fault_addr (fault_addr),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_ack    (mem_ack)
);

// File: tb/pgwalk_xlate_tb.sv
`timescale 1ns/1ps
module pgwalk_xlate_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_wr = 1'b0, rsp_ready = 1'b0, base_wr = 1'b0;
   logic [31:0] req_la = '0, base_din = '0;
   logic        req_ready, rsp_valid, rsp_fault, mem_req, mem_we;
   logic [31:0] rsp_pa, dir_base, fault_addr, mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   logic        host_we = 1'b0;
   logic [31:0] host_addr = '0, host_data = '0;
   logic [31:0] mem [0:4095];
   int          rd_cnt = 0, wr_cnt = 0;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   pgwalk_xlate dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_la(req_la), .req_wr(req_wr),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
      .base_wr(base_wr), .base_din(base_din), .dir_base(dir_base), .fault_addr(fault_addr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   // Memory model: acknowledges one cycle after a request.
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4096; i++) mem[i] <= '0;
         mem_ack <= 1'b0;
      end else begin
         if (host_we) mem[host_addr[13:2]] <= host_data;
         mem_ack <= mem_req && !mem_ack;
         if (mem_req && !mem_ack) begin
            mem_rdata <= mem[mem_addr[13:2]];
            if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
         end
         if (mem_req && mem_ack) begin
            if (mem_we) wr_cnt <= wr_cnt + 1;
            else        rd_cnt <= rd_cnt + 1;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic host_write(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk); host_we = 1'b1; host_addr = a; host_data = d;
      @(negedge clk); host_we = 1'b0;
   endtask

   task automatic write_base(input logic [31:0] d);
      @(negedge clk); base_wr = 1'b1; base_din = d;
      @(negedge clk); base_wr = 1'b0;
   endtask

   task automatic access(input logic [31:0] la, input logic wr, input int hold,
                         output logic flt, output logic [31:0] pa,
                         output int nrd, output int nwr);
      int rd0, wr0;
      @(negedge clk);
      rd0 = rd_cnt; wr0 = wr_cnt;
      req_valid = 1'b1; req_la = la; req_wr = wr;
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      flt = rsp_fault; pa = rsp_pa;
      if (hold > 0) begin
         check("R11 ready low while busy", {31'd0, req_ready}, 32'd0);
         repeat (hold) @(negedge clk);
         check("R11 rsp held valid", {31'd0, rsp_valid}, 32'd1);
         check("R11 rsp pa held", rsp_pa, pa);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      nrd = rd_cnt - rd0; nwr = wr_cnt - wr0;
   endtask

   typedef struct packed {
      logic [31:0] la;
      logic        wr;
      logic        flt;
      logic [31:0] pa;
      logic [3:0]  nrd;
      logic [3:0]  nwr;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_0123, 1'b0, 1'b0, 32'h0AB0_0123, 4'd2, 4'd1},  // R1 R7 miss, A set
      '{32'h0000_0456, 1'b0, 1'b0, 32'h0AB0_0456, 4'd0, 4'd0},  // R5 hit
      '{32'h0000_0010, 1'b1, 1'b0, 32'h0AB0_0010, 4'd2, 4'd1},  // R9 R8 clean write hit
      '{32'h0000_0020, 1'b1, 1'b0, 32'h0AB0_0020, 4'd0, 4'd0},  // R9 dirty write hit
      '{32'h0000_1FFC, 1'b0, 1'b0, 32'h0CD0_0FFC, 4'd2, 4'd0},  // R7 A already set
      '{32'h0000_2000, 1'b0, 1'b1, 32'h0000_0000, 4'd2, 4'd0},  // R3 table fault
      '{32'h0000_2004, 1'b0, 1'b1, 32'h0000_0000, 4'd2, 4'd0},  // R3 not cached
      '{32'h0040_0008, 1'b0, 1'b1, 32'h0000_0000, 4'd1, 4'd0},  // R2 dir fault
      '{32'h0000_3ABC, 1'b1, 1'b0, 32'h0AB0_0ABC, 4'd2, 4'd1},  // R12 R8 alias write
      '{32'h0000_5004, 1'b0, 1'b0, 32'h1110_0004, 4'd2, 4'd0}   // R1 A and D set
   };

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic        f;
      logic [31:0] p;
      int          nr, nw;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 reset req_ready", {31'd0, req_ready}, 32'd1);
      check("R11 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
      check("R11 reset mem_req",   {31'd0, mem_req}, 32'd0);
      check("R4 reset fault_addr", fault_addr, 32'd0);
      check("R6 reset dir_base",   dir_base, 32'd0);

      // Directory at 0x1000, one table at 0x2000.
      host_write(32'h1000, 32'h0000_2001);
      host_write(32'h2000, 32'h0AB0_0001);
      host_write(32'h2004, 32'h0CD0_0021);
      host_write(32'h2008, 32'h0000_0000);
      host_write(32'h200C, 32'h0AB0_0001);
      host_write(32'h2014, 32'h1110_0061);
      write_base(32'h0000_1000);
      check("R6 dir_base loaded", dir_base, 32'h0000_1000);

      for (int i = 0; i < NV; i++) begin
         access(VECS[i].la, VECS[i].wr, 0, f, p, nr, nw);
         check($sformatf("R1 vec%0d fault", i), {31'd0, f}, {31'd0, VECS[i].flt});
         check($sformatf("R1 vec%0d pa", i), p, VECS[i].pa);
         check($sformatf("R5 vec%0d mem reads", i), nr, 32'(VECS[i].nrd));
         check($sformatf("R7 vec%0d mem writes", i), nw, 32'(VECS[i].nwr));
      end
      check("R8 page0 entry A|D", mem[32'h2000 >> 2], 32'h0AB0_0061);
      check("R12 alias entry A|D", mem[32'h200C >> 2], 32'h0AB0_0061);
      check("R7 page1 entry untouched", mem[32'h2004 >> 2], 32'h0CD0_0021);
      check("R4 fault_addr last fault", fault_addr, 32'h0040_0008);

      // R5: stale cached translation survives an invalidated entry
      host_write(32'h2000, 32'h0000_0000);
      access(32'h0000_0004, 1'b0, 0, f, p, nr, nw);
      check("R5 stale hit no fault", {31'd0, f}, 32'd0);
      check("R5 stale hit pa", p, 32'h0AB0_0004);
      check("R5 stale hit no memory", nr + nw, 32'd0);

      // R6: rewrite the same base value, the walk now sees the cleared entry
      write_base(32'h0000_1000);
      access(32'h0000_0008, 1'b0, 0, f, p, nr, nw);
      check("R6 flush forces fault", {31'd0, f}, 32'd1);
      check("R6 flush forces walk", nr, 32'd2);
      check("R4 fault_addr captured", fault_addr, 32'h0000_0008);

      // R10: round robin over 8 entries, pages 16..24
      for (int v = 16; v <= 24; v++)
         host_write(32'h2000 + 32'(v) * 4, ((32'h100 + 32'(v)) << 12) | 32'h61);
      for (int v = 16; v <= 24; v++) begin
         access(32'(v) << 12, 1'b0, (v == 16) ? 3 : 0, f, p, nr, nw);
         check("R10 fill walk", nr, 32'd2);
         check("R10 fill pa", p, (32'h100 + 32'(v)) << 12);
      end
      access(32'(17) << 12, 1'b0, 0, f, p, nr, nw);
      check("R10 second page still cached", nr, 32'd0);
      access(32'(16) << 12, 1'b0, 0, f, p, nr, nw);
      check("R10 first page evicted", nr, 32'd2);
      access(32'(18) << 12, 1'b0, 0, f, p, nr, nw);
      check("R10 third page still cached", nr, 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule